// File: doc/BRIEF.md
# Burst Wrap Address Generator

This block produces the byte address for a serial memory's read burst on the device side. A command path writes a three-bit wrap setting into it. From the next burst onward, each burst loads its start address and steps forward by one byte for every data byte delivered. With wrap turned on, the address stays inside an aligned section of 8, 16, 32 or 64 bytes. The section sits within a 256-byte page. The burst may start partway through the section. After the section's last byte, the address returns to the section's first byte. This repeats until chip select goes high.

With wrap turned off, the address counts through the whole array and rolls over at the top. The setting stays in force for every later burst until it is rewritten. A setting written while a burst runs applies only from the next burst start. The memory array itself lies outside this block. `ADDR_W` must be at least 8.

Top module: `burst_wrap_addr_gen`

## Requirements
- R1: After reset, `addr` is 0 and the stored setting is 3'b001, so wrap is off and the length code is 00.
- R2: A `burst_start` pulse while `cs_n` is low loads `start_addr`, and the value appears on `addr` one clock later.
- R3: The setting is decoded as follows. Bit 0 = 0 turns wrap on and bit 0 = 1 turns it off. Bits 2:1 pick the section length: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bytes.
- R4: With wrap on, each accepted advance steps only the low log2(length) address bits by one and holds the upper bits. The address therefore goes from the section's top byte back to its aligned base, and it keeps cycling for as long as advances continue.
- R5: With wrap off, each accepted advance adds one to the full address, and the top address rolls over to 0.
- R6: A setting written during a burst does not change that burst. The same holds for a write in the same cycle as `burst_start`. Such a write takes effect at the next burst start.
- R7: `advance` is ignored, and `addr` holds, in two cases: while `cs_n` is high, and after `cs_n` has risen until a new `burst_start` arrives.
- R8: A written setting applies to every following burst until it is written again.
- R9: When `burst_start` and `advance` arrive in the same cycle, the load wins and `addr` becomes `start_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the wrap setting |
| cfg_bits | input | 3 | Wrap setting: [0] wrap off when 1, [2:1] length code |
| cs_n | input | 1 | Chip select, active low; high ends the burst |
| burst_start | input | 1 | Begin a read burst at `start_addr` |
| start_addr | input | ADDR_W | Burst start address |
| advance | input | 1 | One data byte delivered |
| addr | output | ADDR_W | Current byte address |

## Verification
The in-line assertions check these properties on every cycle:
- A load is taken.
- A wrapping step never disturbs the upper address bits.
- A linear step adds exactly one.
- The address stays still when no step or load is accepted.
- The per-burst setting is frozen between loads.
- Chip select high ends the burst.

Only the bench's sweeps can show the rest. These cover the exact wrap point for each of the four lengths and for start offsets across the section. They also cover the rollover at the array top, and the ordering of a setting write against a burst start.

// File: rtl/bwag_pkg.sv
package bwag_pkg;

  // [2:1] length code, [0] wrap off when set
  typedef struct packed {
    logic [1:0] len;
    logic       wrap_n;
  } wrap_cfg_t;

  localparam wrap_cfg_t CFG_RESET = '{len: 2'b00, wrap_n: 1'b1};

  // low-bit mask of the section: 8 << code, minus one
  function automatic logic [7:0] sect_mask(input logic [1:0] code);
    return (8'd8 << code) - 8'd1;
  endfunction

endpackage

// File: rtl/bwag_cfg_store.sv
module bwag_cfg_store
  import bwag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  wrap_cfg_t d,
  output wrap_cfg_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= CFG_RESET;
    else if (we) q <= d;
  end

  // R3 / R8: a write is captured and then kept
  a_r3_cfg_capture: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d));
  a_r8_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/bwag_step.sv
module bwag_step
  import bwag_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur,
  input  wrap_cfg_t         cfg,
  output logic [ADDR_W-1:0] nxt,
  output logic [ADDR_W-1:0] low_mask,
  output logic              wrap_on
);

  localparam int PAD_W = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] m,
    input logic              wrap
  );
    logic [ADDR_W-1:0] inc;
    inc = a + 1'b1;
    return wrap ? ((a & ~m) | (inc & m)) : inc;
  endfunction

  always_comb begin
    low_mask = {{PAD_W{1'b0}}, sect_mask(cfg.len)};
    wrap_on  = ~cfg.wrap_n;
    nxt      = step_addr(cur, low_mask, wrap_on);
  end

endmodule

// File: rtl/burst_wrap_addr_gen.sv
module burst_wrap_addr_gen
  import bwag_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_bits,
  input  logic              cs_n,
  input  logic              burst_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);

  wrap_cfg_t         cfg_stored;
  wrap_cfg_t         cfg_burst;
  logic              active;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] low_mask;
  logic              wrap_on;

  // named events
  logic load_fire;
  logic step_fire;
  assign load_fire = burst_start & ~cs_n;
  assign step_fire = advance & active & ~cs_n & ~burst_start;

  bwag_cfg_store u_cfg (
    .clk (clk),
    .rst_n (rst_n),
    .we (cfg_we),
    .d (wrap_cfg_t'(cfg_bits)),
    .q (cfg_stored)
  );

  bwag_step #(.ADDR_W(ADDR_W)) u_step (
    .cur (addr),
    .cfg (cfg_burst),
    .nxt (nxt_addr),
    .low_mask (low_mask),
    .wrap_on (wrap_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      addr      <= '0;
      cfg_burst <= CFG_RESET;
    end else begin
      if (cs_n)             active <= 1'b0;
      else if (burst_start) active <= 1'b1;
      if (load_fire) begin
        addr      <= start_addr;
        cfg_burst <= cfg_stored;
      end else if (step_fire) begin
        addr <= nxt_addr;
      end
    end
  end

  // R2 / R9: a load takes the start address
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> addr == $past(start_addr));
  // R4: wrapping step leaves upper bits untouched
  a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && wrap_on |=> ((addr ^ $past(addr)) & ~$past(low_mask)) == '0);
  // R5: linear step adds one
  a_r5_linear: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && !wrap_on |=> addr == ADDR_W'($past(addr) + 1'b1));
  // R7: no accepted event, no movement
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire && !step_fire |=> $stable(addr));
  a_r7_cs_ends: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !active);
  // R6: burst setting only moves at a load
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable(cfg_burst));

endmodule

// File: tb/burst_wrap_addr_gen_test.sv
module burst_wrap_addr_gen_test;
  localparam int AW = 10;
  localparam int TOP = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_bits = 3'b000;
  logic cs_n = 1'b1;
  logic burst_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic advance = 1'b0;
  logic [AW-1:0] addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_wrap_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bits(cfg_bits),
    .cs_n(cs_n), .burst_start(burst_start), .start_addr(start_addr),
    .advance(advance), .addr(addr)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int expect_at(input int s, input int k, input bit wrap, input int code);
    int len;
    len = 8 << code;
    if (wrap) return (s - (s % len)) + ((s % len) + k) % len;
    return (s + k) % TOP;
  endfunction

  task automatic write_cfg(input bit wrap, input int code);
    cfg_bits = {2'(code), ~wrap};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic begin_burst(input int s);
    cs_n = 1'b0;
    start_addr = AW'(s);
    burst_start = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  task automatic end_burst();
    cs_n = 1'b1;
    advance = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_burst(input string req, input int s, input int n,
                           input bit wrap, input int code);
    begin_burst(s);
    chk("R2", int'(addr), s);
    advance = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk(req, int'(addr), expect_at(s, k, wrap, code));
    end
    end_burst();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1", int'(addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset setting is wrap off
    run_burst("R1", 5, 12, 1'b0, 0);

    // R3 R4: every length, wrap on, starts across a page
    for (int code = 0; code < 4; code++) begin
      write_cfg(1'b1, code);
      for (int s = 0; s < TOP; s += 37)
        run_burst("R4", s, 2 * (8 << code) + 3, 1'b1, code);
    end
    // R3: each top byte of a section returns to base
    for (int code = 0; code < 4; code++) begin
      write_cfg(1'b1, code);
      run_burst("R3", 256 + (8 << code) - 1, 1, 1'b1, code);
    end

    // R5: wrap off, rollover at top
    write_cfg(1'b0, 3);
    run_burst("R5", TOP - 3, 6, 1'b0, 3);
    run_burst("R5", 100, 70, 1'b0, 3);

    // R8: setting persists across bursts
    write_cfg(1'b1, 1);
    run_burst("R8", 40, 20, 1'b1, 1);
    run_burst("R8", 700, 20, 1'b1, 1);

    // R6: write during a burst waits for the next start
    write_cfg(1'b0, 0);
    begin_burst(4);
    advance = 1'b1;
    @(negedge clk);
    cfg_bits = 3'b000; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int k = 3; k <= 10; k++) begin
      @(negedge clk);
      chk("R6", int'(addr), expect_at(4, k, 1'b0, 0));
    end
    end_burst();
    run_burst("R6", 4, 10, 1'b1, 0);
    // R6: same-cycle write and start uses old setting
    cs_n = 1'b0; start_addr = AW'(6); burst_start = 1'b1;
    cfg_bits = 3'b001; cfg_we = 1'b1;
    @(negedge clk);
    burst_start = 1'b0; cfg_we = 1'b0; advance = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6", int'(addr), expect_at(6, 3, 1'b1, 0));
    end_burst();
    run_burst("R6", 6, 3, 1'b0, 0);

    // R7: cs high ignores advance; no restart ignores advance
    begin_burst(50);
    end_burst();
    advance = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", int'(addr), 50);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7", int'(addr), 50);
    end_burst();

    // R9: start and advance together
    cs_n = 1'b0; advance = 1'b1; start_addr = AW'(300); burst_start = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
    chk("R9", int'(addr), 300);
    @(negedge clk);
    chk("R9", int'(addr), 301);
    end_burst();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule